// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a bank of general-purpose pins controlled through a small 32-bit register bus. Each pin has a direction bit and an output latch. The latch is changed only through two write-only-style registers: one that sets the bits written as 1 and one that clears them. This lets software move single pins without a read-modify-write. Pin levels pass through a two-flop synchronizer. The synchronized value can be read back and is also what drives the interrupt logic.

Each pin has its own interrupt detector. Software chooses per pin between edge and level detection, chooses the active polarity, and can gate the pin with two independent bits, an enable and a mask. A pending register records events. The block has one combined interrupt output, registered, which is high while any pin is pending, enabled and unmasked.

Software can detect both edges by flipping a pin's polarity after each event. This works because a polarity change by itself never creates an edge event. A build parameter decides whether a direction bit of 1 turns the output driver on or makes the pin an input.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, all writable registers and all pending bits read 0, `pin_out` is 0 and `irq` is 0. With DIR_IS_INPUT=0 `pin_oe` is all zeros. With DIR_IS_INPUT=1 it is all ones.
- R2: The direction register is at offset 0x00. With DIR_IS_INPUT=0, `pin_oe[i]` equals direction bit i. With DIR_IS_INPUT=1, `pin_oe[i]` is the inverse of direction bit i.
- R3: A write to offset 0x0C sets each output latch bit whose data bit is 1 and leaves the other bits unchanged. Reads of 0x0C and of 0x10 both return the output latch, which also drives `pin_out`.
- R4: A write to offset 0x10 clears each output latch bit whose data bit is 1 and leaves the other bits unchanged.
- R5: Offset 0x04 reads the pin inputs after a two-flop synchronizer.
- R6: Register bits at positions PIN_COUNT and above read as 0 and ignore writes.
- R7: With type bit 0 (offset 0x18), a pin detects edges. Polarity bit 1 (offset 0x1C) selects a rising edge and 0 selects a falling edge. An edge is captured only while the enable bit (offset 0x14) is 1. It sets the pending bit (offset 0x20), which then holds until software writes 1 to that bit of 0x20.
- R8: With type bit 1, the pending bit follows (enable AND input equals polarity) every cycle, and writing 1 to it has no lasting effect.
- R9: Changing a pin's polarity or type without any change on the pin never sets an edge pending bit.
- R10: `irq` goes high one cycle after some pin has its pending, enable and mask (offset 0x24) bits all 1, and is low otherwise. Clearing either the enable or the mask bit alone blocks the pin.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Reads of any offset not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output latch |
| pin_oe | output | PIN_COUNT | Output driver enable per pin |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds two copies of the block on a shared bus:
- One copy has eight pins and direction bit 1 meaning output. It carries the vector walk through the output, direction and unmapped-read behaviour, and then directed interrupt sequences on three pins that cover rising edges, falling edges and level detection.
- The other copy has five pins and the inverted direction sense. With it, the inverted `pin_oe` mapping and its reset value can be observed. Its odd width also shows upper-bit masking on a bank that is not a power of two wide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_DW = 32;
    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFS_DIR  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_IN   = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_SET  = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_CLR  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_EN   = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_TYPE = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_POL  = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_PEND = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_MASK = 8'h24;

    typedef enum logic [3:0] {
        SEL_DIR, SEL_IN, SEL_SET, SEL_CLR, SEL_EN,
        SEL_TYPE, SEL_POL, SEL_PEND, SEL_MASK, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] ofs);
        case (ofs)
            OFS_DIR:  return SEL_DIR;
            OFS_IN:   return SEL_IN;
            OFS_SET:  return SEL_SET;
            OFS_CLR:  return SEL_CLR;
            OFS_EN:   return SEL_EN;
            OFS_TYPE: return SEL_TYPE;
            OFS_POL:  return SEL_POL;
            OFS_PEND: return SEL_PEND;
            OFS_MASK: return SEL_MASK;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] is_level,
    input  logic [WIDTH-1:0] polarity,
    input  logic [WIDTH-1:0] ack,
    output logic [WIDTH-1:0] pending
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] pend;
    } det_t;

    det_t st_d, st_q;

    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] lvl_hit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic rise_w, fall_w;
        assign rise_w      = level[i] & ~st_q.prev[i];
        assign fall_w      = ~level[i] & st_q.prev[i];
        assign edge_hit[i] = enable[i] & (polarity[i] ? rise_w : fall_w);
        assign lvl_hit[i]  = enable[i] & (level[i] == polarity[i]);

        // R9
        no_spurious_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level[i] && !st_q.pend[i] && (level[i] == st_q.prev[i])) |=> !pending[i]);
        // R7
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level[i] && pending[i] && !ack[i]) |=> pending[i]);
        // R8
        level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_level[i] && enable[i] && (level[i] == polarity[i])) |=> pending[i]);
    end

    always_comb begin
        st_d.prev = level;
        for (int i = 0; i < WIDTH; i++) begin
            if (is_level[i]) st_d.pend[i] = lvl_hit[i];
            else             st_d.pend[i] = edge_hit[i] | (st_q.pend[i] & ~ack[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int PIN_COUNT    = 8,
    parameter bit DIR_IS_INPUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam int PAD = BUS_DW - PIN_COUNT;

    typedef struct packed {
        logic [PIN_COUNT-1:0] dir;
        logic [PIN_COUNT-1:0] out;
        logic [PIN_COUNT-1:0] en;
        logic [PIN_COUNT-1:0] typ;
        logic [PIN_COUNT-1:0] pol;
        logic [PIN_COUNT-1:0] mask;
        logic [BUS_DW-1:0]    rdata;
        logic                 irq;
    } bank_t;

    bank_t r_d, r_q;

    reg_sel_e             sel;
    logic [PIN_COUNT-1:0] wbits;
    logic [PIN_COUNT-1:0] pin_sync;
    logic [PIN_COUNT-1:0] pend;
    logic [PIN_COUNT-1:0] ack;
    logic [PIN_COUNT-1:0] rd_bits;

    assign sel   = decode_ofs(bus_addr);
    assign wbits = bus_wdata[PIN_COUNT-1:0];
    assign ack   = (bus_wr && sel == SEL_PEND) ? wbits : '0;

    gpio_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_irq_detect #(.WIDTH(PIN_COUNT)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_sync),
        .enable   (r_q.en),
        .is_level (r_q.typ),
        .polarity (r_q.pol),
        .ack      (ack),
        .pending  (pend)
    );

    always_comb begin
        case (sel)
            SEL_DIR:          rd_bits = r_q.dir;
            SEL_IN:           rd_bits = pin_sync;
            SEL_SET, SEL_CLR: rd_bits = r_q.out;
            SEL_EN:           rd_bits = r_q.en;
            SEL_TYPE:         rd_bits = r_q.typ;
            SEL_POL:          rd_bits = r_q.pol;
            SEL_PEND:         rd_bits = pend;
            SEL_MASK:         rd_bits = r_q.mask;
            default:          rd_bits = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (sel)
                SEL_DIR:  r_d.dir  = wbits;
                SEL_SET:  r_d.out  = r_q.out | wbits;
                SEL_CLR:  r_d.out  = r_q.out & ~wbits;
                SEL_EN:   r_d.en   = wbits;
                SEL_TYPE: r_d.typ  = wbits;
                SEL_POL:  r_d.pol  = wbits;
                SEL_MASK: r_d.mask = wbits;
                default:  ;
            endcase
        end
        r_d.rdata = bus_rd ? {{PAD{1'b0}}, rd_bits} : '0;
        r_d.irq   = |(pend & r_q.en & r_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    if (DIR_IS_INPUT) begin : g_dir_inv
        assign pin_oe = ~r_q.dir;
    end else begin : g_dir_pos
        assign pin_oe = r_q.dir;
    end

    assign pin_out   = r_q.out;
    assign bus_rdata = r_q.rdata;
    assign irq       = r_q.irq;

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_SET) |=> ((pin_out & $past(wbits)) == $past(wbits)));
    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_CLR) |=> ((pin_out & $past(wbits)) == '0));
    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(r_q.en & r_q.mask)) |=> !irq);
    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[BUS_DW-1:PIN_COUNT] == '0));

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [7:0]  pin_in = '0;
    logic [7:0]  out_a, oe_a;
    logic [4:0]  out_b, oe_b;
    logic        irq_a, irq_b;

    int total = 0;
    int bad = 0;
    logic [31:0] got_a, got_b;

    always #5 clk = ~clk;

    gpio_irq_bank #(.PIN_COUNT(8), .DIR_IS_INPUT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

    gpio_irq_bank #(.PIN_COUNT(5), .DIR_IS_INPUT(1'b1)) u_dut_inv (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .pin_in(pin_in[4:0]), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 32'h0000_00F0, 32'h0, 8'd2},
        '{1'b0, 8'h00, 32'h0,         32'h0000_00F0, 8'd2},  // R2
        '{1'b1, 8'h0C, 32'h0000_0F0F, 32'h0, 8'd3},
        '{1'b0, 8'h0C, 32'h0,         32'h0000_000F, 8'd6},  // R6
        '{1'b1, 8'h0C, 32'h0000_0030, 32'h0, 8'd3},
        '{1'b0, 8'h10, 32'h0,         32'h0000_003F, 8'd3},  // R3
        '{1'b1, 8'h10, 32'h0000_0005, 32'h0, 8'd4},
        '{1'b0, 8'h0C, 32'h0,         32'h0000_003A, 8'd4},  // R4
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0, 8'd6},
        '{1'b0, 8'h24, 32'h0,         32'h0000_00FF, 8'd6},  // R6
        '{1'b0, 8'h08, 32'h0,         32'h0,         8'd11}, // R11
        '{1'b0, 8'h28, 32'h0,         32'h0,         8'd11}, // R11
        '{1'b1, 8'h24, 32'h0,         32'h0,         8'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        got_a = rdata_a; got_b = rdata_b;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 pin_out", {24'h0, out_a}, 32'h0);
        check("R1 pin_oe", {24'h0, oe_a}, 32'h0);
        check("R1 pin_oe inverted", {27'h0, oe_b}, 32'h1F);
        check("R1 irq", {31'h0, irq_a}, 32'h0);
        for (int k = 0; k < 10; k++) begin
            rd(8'(k * 4));
            check("R1 register", got_a, 32'h0);
        end

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].wr) wr(VEC[v].addr, VEC[v].data);
            else begin
                rd(VEC[v].addr);
                check($sformatf("R%0d vector %0d", VEC[v].req, v), got_a, VEC[v].expd);
            end
        end
        check("R3 pin_out", {24'h0, out_a}, 32'h3A);
        check("R2 pin_oe", {24'h0, oe_a}, 32'hF0);
        check("R2 pin_oe inverted", {27'h0, oe_b}, 32'h0F);

        // R5 synchronized input
        pin_in = 8'hA5;
        idle(3);
        rd(8'h04);
        check("R5 input", got_a, 32'hA5);
        check("R6 input narrow", got_b, 32'h05);
        pin_in = 8'h00;
        idle(4);
        wr(8'h20, 32'hFF);

        // R7 rising edge on pin 0
        wr(8'h18, 32'h00);
        wr(8'h1C, 32'h01);
        wr(8'h24, 32'h01);
        wr(8'h14, 32'h01);
        pin_in = 8'h01;
        idle(4);
        rd(8'h20);
        check("R7 rising pend", got_a, 32'h01);
        check("R10 irq on", {31'h0, irq_a}, 32'h1);
        pin_in = 8'h00;
        idle(4);
        rd(8'h20);
        check("R7 pend held", got_a, 32'h01);
        wr(8'h20, 32'h01);
        idle(2);
        rd(8'h20);
        check("R7 ack clears", got_a, 32'h0);
        check("R10 irq off", {31'h0, irq_a}, 32'h0);

        // R9 polarity flip with steady pin
        wr(8'h1C, 32'h00);
        idle(3);
        rd(8'h20);
        check("R9 pol to falling", got_a, 32'h0);
        wr(8'h1C, 32'h01);
        idle(3);
        rd(8'h20);
        check("R9 pol to rising", got_a, 32'h0);

        // R7 falling edge on pin 1, R10 gating
        wr(8'h14, 32'h02);
        wr(8'h1C, 32'h00);
        wr(8'h24, 32'h00);
        pin_in = 8'h02;
        idle(4);
        rd(8'h20);
        check("R7 rising ignored on falling pin", got_a, 32'h0);
        pin_in = 8'h00;
        idle(4);
        rd(8'h20);
        check("R7 falling pend", got_a, 32'h02);
        check("R10 masked", {31'h0, irq_a}, 32'h0);
        wr(8'h24, 32'h02);
        idle(2);
        check("R10 unmasked", {31'h0, irq_a}, 32'h1);
        wr(8'h14, 32'h00);
        idle(2);
        check("R10 disabled", {31'h0, irq_a}, 32'h0);
        rd(8'h20);
        check("R7 pend kept while disabled", got_a, 32'h02);
        wr(8'h20, 32'h02);

        // R8 level on pin 2
        wr(8'h18, 32'h04);
        wr(8'h1C, 32'h04);
        wr(8'h24, 32'h04);
        wr(8'h14, 32'h04);
        idle(2);
        rd(8'h20);
        check("R8 level inactive", got_a, 32'h0);
        pin_in = 8'h04;
        idle(4);
        rd(8'h20);
        check("R8 level active", got_a, 32'h04);
        check("R10 level irq", {31'h0, irq_a}, 32'h1);
        wr(8'h20, 32'h04);
        idle(2);
        rd(8'h20);
        check("R8 ack no effect", got_a, 32'h04);
        pin_in = 8'h00;
        idle(4);
        rd(8'h20);
        check("R8 level drops", got_a, 32'h0);
        check("R10 level irq off", {31'h0, irq_a}, 32'h0);
        wr(8'h1C, 32'h00);
        idle(2);
        rd(8'h20);
        check("R8 low polarity", got_a, 32'h04);

        // R6 on the narrow bank
        wr(8'h24, 32'hFF);
        rd(8'h24);
        check("R6 wide mask", got_a, 32'hFF);
        check("R6 narrow mask", got_b, 32'h1F);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule